// File: doc/BRIEF.md
# Transactional Performance Event Monitor

This block sits beside one processor's transactional cache and keeps a snapshot of the two most expensive kinds of transactional event. When a dependency violation aborts the running transaction, the monitor stores four things: the snooped object address, the ID of the remote thread that wrote it, the PC of the load that first read that address inside the transaction, and the number of useful cycles the transaction had run before the violation. When the speculative buffer overflows, it stores the PC at the overflow and the overflow type. It then times how long the processor runs serialized while it holds the commit token, and finishes the record when that transaction commits.

Each record has a valid flag, a saturating occurrence count and a saturating dropped-event count. Software polls the records through a small word-addressed read port. Reading a record's status word with the read strobe hands the record back to the hardware. Software can then rank the reported events by frequency and by lost cycles.

To keep the block small, first-read PCs come from a short table. The table holds the first load PC of each distinct address read since the transaction began. When an address is not in the table, its PC is reported as zero.

Top module: `tem_event_monitor`

## Requirements
- R1: After synchronous reset every readable word (offsets 0 to 8) reads zero.
- R2: A cycle with `viol_valid` high and no valid conflict record captures `viol_addr` into offset 1 and `viol_writer` into offset 3. It also sets bit 0 (valid) of the conflict status word at offset 0, visible on the next cycle.
- R3: The conflict PC at offset 2 is the PC of the first load to the violated address since the last `tx_start`. Later loads to the same address do not change it.
- R4: The conflict PC reads zero when the violated address was never loaded in the transaction. It also reads zero when the address arrived after the table already held DEPTH (default 4) distinct addresses.
- R5: The lost-cycle count at offset 4 equals the number of clock cycles strictly between the cycle that sampled `tx_start` and the cycle that sampled `viol_valid`.
- R6: A cycle with `ovf_valid` high and no valid or pending overflow record latches `ovf_pc` (offset 6) and `ovf_type` (offset 7). At the next `tx_commit`, offset 8 gets the number of cycles strictly between the overflow cycle and the commit cycle, and bit 0 of the overflow status word at offset 5 is set. The valid bit stays clear before the commit.
- R7: A `tx_abort` while an overflow is pending discards it: the overflow valid bit stays clear, including through later commits.
- R8: A cycle with `rd_en` high and `rd_addr` equal to 0 (or 5) clears the conflict (or overflow) valid bit. A read strobe at any other offset clears nothing.
- R9: An event that arrives while its record is valid (or, for overflows, pending) leaves the record unchanged. It increments the dropped count in status bits [31:16].
- R10: Status bits [15:8] count every event of that kind, captured or dropped. Both the occurrence count and the dropped count saturate at 255 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_start | input | 1 | Transaction begins this cycle |
| tx_commit | input | 1 | Transaction commits this cycle |
| tx_abort | input | 1 | Transaction aborts this cycle |
| ld_valid | input | 1 | Transactional load this cycle |
| ld_addr | input | AW | Load address |
| ld_pc | input | PW | Load PC |
| viol_valid | input | 1 | Dependency violation snooped this cycle |
| viol_addr | input | AW | Conflicting object address |
| viol_writer | input | TW | ID of the committing writer thread |
| ovf_valid | input | 1 | Speculative buffer overflow this cycle |
| ovf_type | input | OTW | Overflow kind code |
| ovf_pc | input | PW | PC at the overflow |
| rd_en | input | 1 | Read strobe (clears valid on a status offset) |
| rd_addr | input | 4 | Word offset |
| rd_data | output | 32 | Word at `rd_addr`, combinational |

## Verification
Most internal faults in this block surface at the read port within one cycle of the event that exposes them. A stuck or mis-cleared cycle counter shows up as a lost-cycle or duration value off by a fixed amount. A table that overwrites entries shows up as the PC of a later load instead of the first one. A broken valid/drop interlock shows up as an overwritten address or a dropped count that does not move. Saturation faults only show after hundreds of events, so a long burst of back-to-back violations checks both counters at their ceiling.

// File: rtl/tem_pkg.sv
// Package: shared constants and the read-port word map of the event monitor.
// Assumes a 32-bit read port; status words pack valid, occurrence and drop counts.
package tem_pkg;
    localparam int unsigned DW = 32;
    localparam int unsigned OCC_POS = 8;
    localparam int unsigned DROP_POS = 16;

    typedef enum logic [3:0] {
        REG_CF_STAT   = 4'd0,
        REG_CF_ADDR   = 4'd1,
        REG_CF_PC     = 4'd2,
        REG_CF_WRITER = 4'd3,
        REG_CF_LOSS   = 4'd4,
        REG_OV_STAT   = 4'd5,
        REG_OV_PC     = 4'd6,
        REG_OV_TYPE   = 4'd7,
        REG_OV_DUR    = 4'd8
    } reg_sel_e;
endpackage

// File: rtl/tem_sat_counter.sv
// Module: saturating up-counter with synchronous clear.
// Assumes clr has priority over inc; the count holds at its all-ones value.
module tem_sat_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    // Count up to the ceiling, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n)               q <= '0;
        else if (clr)             q <= '0;
        else if (inc && q != MAX) q <= q + 1'b1;
    end

    // R10
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q == MAX && !clr) |=> (q == MAX));
endmodule

// File: rtl/tem_first_read_table.sv
// Module: small fully associative table of first-read PCs.
// Records the first load PC of each distinct address since clr. It fills in
// order and ignores new addresses once full. The lookup returns zero on a miss.
module tem_first_read_table #(
    parameter int unsigned AW    = 32,
    parameter int unsigned PW    = 32,
    parameter int unsigned DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    input  logic [PW-1:0] ld_pc,
    input  logic [AW-1:0] q_addr,
    output logic [PW-1:0] q_pc
);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned PTR_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] FULL = PTR_W'(DEPTH);

    logic [DEPTH-1:0] ent_v;
    logic [AW-1:0]    ent_addr [DEPTH];
    logic [PW-1:0]    ent_pc   [DEPTH];
    logic [PTR_W-1:0] fill;
    logic [DEPTH-1:0] ld_match, q_match;
    logic             ld_hit;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign ld_match[i] = ent_v[i] && (ent_addr[i] == ld_addr);
        assign q_match[i]  = ent_v[i] && (ent_addr[i] == q_addr);

        // R3
        first_pc_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ent_v[i] && !clr) |=> ($stable(ent_pc[i]) && $stable(ent_addr[i])));
    end

    assign ld_hit = |ld_match;

    // Select the PC of the matching entry, zero on miss.
    always_comb begin
        q_pc = '0;
        for (int i = 0; i < DEPTH; i++)
            if (q_match[i]) q_pc = ent_pc[i];
    end

    // Track valid entries and the fill pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ent_v <= '0;
            fill  <= '0;
        end else if (ld_valid && !ld_hit && fill != FULL) begin
            ent_v[fill[IDX_W-1:0]] <= 1'b1;
            fill <= fill + 1'b1;
        end
    end

    // Store address and PC of a newly inserted entry.
    always_ff @(posedge clk) begin
        if (rst_n && !clr && ld_valid && !ld_hit && fill != FULL) begin
            ent_addr[fill[IDX_W-1:0]] <= ld_addr;
            ent_pc[fill[IDX_W-1:0]]   <= ld_pc;
        end
    end
endmodule

// File: rtl/tem_event_monitor.sv
// Module: per-processor monitor of costly transactional events.
// Holds one conflict record and one overflow record, each with a valid flag,
// an occurrence count and a dropped count, all read through a word port.
// Assumes AW, PW <= 32, OCC_W <= 8, DROP_W <= 16; one transaction at a time.
module tem_event_monitor
    import tem_pkg::*;
#(
    parameter int unsigned AW     = 32,
    parameter int unsigned PW     = 32,
    parameter int unsigned TW     = 3,
    parameter int unsigned OTW    = 2,
    parameter int unsigned CW     = 24,
    parameter int unsigned OCC_W  = 8,
    parameter int unsigned DROP_W = 8,
    parameter int unsigned DEPTH  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tx_start,
    input  logic           tx_commit,
    input  logic           tx_abort,
    input  logic           ld_valid,
    input  logic [AW-1:0]  ld_addr,
    input  logic [PW-1:0]  ld_pc,
    input  logic           viol_valid,
    input  logic [AW-1:0]  viol_addr,
    input  logic [TW-1:0]  viol_writer,
    input  logic           ovf_valid,
    input  logic [OTW-1:0] ovf_type,
    input  logic [PW-1:0]  ovf_pc,
    input  logic           rd_en,
    input  logic [3:0]     rd_addr,
    output logic [31:0]    rd_data
);
    logic              in_tx;
    logic [CW-1:0]     tx_cycles, ov_cycles;
    logic [PW-1:0]     first_pc;
    logic              cf_valid, ov_valid, ov_pend;
    logic [AW-1:0]     cf_addr;
    logic [TW-1:0]     cf_writer;
    logic [PW-1:0]     cf_pc, ov_pc;
    logic [CW-1:0]     cf_loss, ov_dur;
    logic [OTW-1:0]    ov_type;
    logic [OCC_W-1:0]  cf_occ, ov_occ;
    logic [DROP_W-1:0] cf_drop, ov_drop;
    logic              cf_accept, ov_accept, cf_rd_clr, ov_rd_clr, ov_done;
    logic [DW-1:0]     cf_stat, ov_stat;

    assign cf_accept = viol_valid && !cf_valid;
    assign ov_accept = ovf_valid && !ov_valid && !ov_pend;
    assign ov_done   = ov_pend && tx_commit;
    assign cf_rd_clr = rd_en && (rd_addr == REG_CF_STAT);
    assign ov_rd_clr = rd_en && (rd_addr == REG_OV_STAT);

    tem_first_read_table #(.AW(AW), .PW(PW), .DEPTH(DEPTH)) u_tbl (
        .clk(clk), .rst_n(rst_n), .clr(tx_start),
        .ld_valid(ld_valid && in_tx), .ld_addr(ld_addr), .ld_pc(ld_pc),
        .q_addr(viol_addr), .q_pc(first_pc)
    );

    tem_sat_counter #(.W(CW)) u_txcyc (
        .clk(clk), .rst_n(rst_n), .clr(tx_start), .inc(in_tx), .q(tx_cycles));
    tem_sat_counter #(.W(CW)) u_ovcyc (
        .clk(clk), .rst_n(rst_n), .clr(ov_accept), .inc(ov_pend), .q(ov_cycles));
    tem_sat_counter #(.W(OCC_W)) u_cfocc (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .inc(viol_valid), .q(cf_occ));
    tem_sat_counter #(.W(OCC_W)) u_ovocc (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .inc(ovf_valid), .q(ov_occ));
    tem_sat_counter #(.W(DROP_W)) u_cfdrop (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .inc(viol_valid && cf_valid), .q(cf_drop));
    tem_sat_counter #(.W(DROP_W)) u_ovdrop (
        .clk(clk), .rst_n(rst_n), .clr(1'b0),
        .inc(ovf_valid && (ov_valid || ov_pend)), .q(ov_drop));

    // Track whether a transaction is running.
    always_ff @(posedge clk) begin
        if (!rst_n)                      in_tx <= 1'b0;
        else if (tx_start)               in_tx <= 1'b1;
        else if (tx_commit || tx_abort)  in_tx <= 1'b0;
    end

    // Capture a conflict record and hand it back on a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cf_valid  <= 1'b0;
            cf_addr   <= '0;
            cf_writer <= '0;
            cf_pc     <= '0;
            cf_loss   <= '0;
        end else if (cf_accept) begin
            cf_valid  <= 1'b1;
            cf_addr   <= viol_addr;
            cf_writer <= viol_writer;
            cf_pc     <= first_pc;
            cf_loss   <= tx_cycles;
        end else if (cf_rd_clr) begin
            cf_valid  <= 1'b0;
        end
    end

    // Open an overflow record, time it until commit, drop it on abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_pend  <= 1'b0;
            ov_valid <= 1'b0;
            ov_pc    <= '0;
            ov_type  <= '0;
            ov_dur   <= '0;
        end else if (ov_accept) begin
            ov_pend  <= 1'b1;
            ov_pc    <= ovf_pc;
            ov_type  <= ovf_type;
        end else if (ov_done) begin
            ov_pend  <= 1'b0;
            ov_valid <= 1'b1;
            ov_dur   <= ov_cycles;
        end else begin
            if (tx_abort || tx_start) ov_pend  <= 1'b0;
            if (ov_rd_clr)            ov_valid <= 1'b0;
        end
    end

    assign cf_stat = (DW'(cf_drop) << DROP_POS) | (DW'(cf_occ) << OCC_POS) | DW'(cf_valid);
    assign ov_stat = (DW'(ov_drop) << DROP_POS) | (DW'(ov_occ) << OCC_POS) | DW'(ov_valid);

    // Word-select the read port.
    always_comb begin
        case (reg_sel_e'(rd_addr))
            REG_CF_STAT:   rd_data = cf_stat;
            REG_CF_ADDR:   rd_data = DW'(cf_addr);
            REG_CF_PC:     rd_data = DW'(cf_pc);
            REG_CF_WRITER: rd_data = DW'(cf_writer);
            REG_CF_LOSS:   rd_data = DW'(cf_loss);
            REG_OV_STAT:   rd_data = ov_stat;
            REG_OV_PC:     rd_data = DW'(ov_pc);
            REG_OV_TYPE:   rd_data = DW'(ov_type);
            REG_OV_DUR:    rd_data = DW'(ov_dur);
            default:       rd_data = '0;
        endcase
    end

    // R2
    cf_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cf_valid) |-> $past(viol_valid));
    // R6
    ov_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ov_valid) |-> $past(tx_commit));
    // R8
    cf_rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cf_rd_clr && cf_valid) |=> !cf_valid);
    // R9
    cf_no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid && cf_valid) |=> ($stable(cf_addr) && $stable(cf_writer) && $stable(cf_pc)));
endmodule

// File: tb/sim_tem_event_monitor.sv
module sim_tem_event_monitor;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tx_start, tx_commit, tx_abort, ld_valid, viol_valid, ovf_valid, rd_en;
    logic [31:0] ld_addr, ld_pc, viol_addr, ovf_pc;
    logic [2:0]  viol_writer;
    logic [1:0]  ovf_type;
    logic [3:0]  rd_addr;
    logic [31:0] rd_data;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tem_event_monitor u0 (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_commit(tx_commit),
        .tx_abort(tx_abort), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_pc(ld_pc),
        .viol_valid(viol_valid), .viol_addr(viol_addr), .viol_writer(viol_writer),
        .ovf_valid(ovf_valid), .ovf_type(ovf_type), .ovf_pc(ovf_pc),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Vector table: violated address, idle gap, writer, expected first-read PC.
    localparam int NV = 4;
    localparam logic [31:0] V_ADDR [NV] = '{32'h100, 32'h200, 32'h300, 32'h100};
    localparam int          V_GAP  [NV] = '{0, 2, 7, 20};
    localparam logic [2:0]  V_WR   [NV] = '{3'd1, 3'd5, 3'd7, 3'd0};
    localparam logic [31:0] V_PC   [NV] = '{32'h1000, 32'h1004, 32'h0, 32'h1000};

    function automatic logic [31:0] stat(input int v, input int occ, input int drop);
        return (32'(drop) << 16) | (32'(occ) << 8) | 32'(v);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
        tx_start = 0; tx_commit = 0; tx_abort = 0; ld_valid = 0;
        viol_valid = 0; ovf_valid = 0; rd_en = 0;
    endtask

    task automatic check(input string req, input logic [3:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s offset %0d actual %h expected %h", req, a, rd_data, exp);
        end
    endtask

    task automatic ld(input logic [31:0] a, input logic [31:0] pc);
        ld_valid = 1; ld_addr = a; ld_pc = pc; tick();
    endtask

    task automatic viol(input logic [31:0] a, input logic [2:0] w);
        viol_valid = 1; viol_addr = a; viol_writer = w; tick();
    endtask

    task automatic pop(input logic [3:0] a);
        rd_en = 1; rd_addr = a; tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; tx_start = 0; tx_commit = 0; tx_abort = 0; ld_valid = 0;
        viol_valid = 0; ovf_valid = 0; rd_en = 0; rd_addr = 0;
        ld_addr = 0; ld_pc = 0; viol_addr = 0; viol_writer = 0; ovf_pc = 0; ovf_type = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: everything reads zero after reset
        for (int a = 0; a <= 8; a++) check("R1", 4'(a), 32'h0);

        // Table walk: R2, R3, R5, R8 over several address/gap patterns
        for (int i = 0; i < NV; i++) begin
            tx_start = 1; tick();
            ld(32'h100, 32'h1000);
            ld(32'h200, 32'h1004);
            ld(32'h100, 32'h1008);
            repeat (V_GAP[i]) tick();
            viol(V_ADDR[i], V_WR[i]);
            tx_abort = 1; tick();
            check("R2", 4'd0, stat(1, i + 1, 0));
            check("R2", 4'd1, V_ADDR[i]);
            check("R2", 4'd3, 32'(V_WR[i]));
            check("R3", 4'd2, V_PC[i]);
            check("R5", 4'd4, 32'(3 + V_GAP[i]));
            pop(4'd0);
            check("R8", 4'd0, stat(0, i + 1, 0));
        end

        // R4: table full, fifth distinct address reports PC zero
        tx_start = 1; tick();
        ld(32'h10, 32'hA0); ld(32'h20, 32'hB0); ld(32'h30, 32'hC0);
        ld(32'h40, 32'hD0); ld(32'h50, 32'hE0);
        viol(32'h50, 3'd4);
        tx_abort = 1; tick();
        check("R4", 4'd2, 32'h0);
        check("R5", 4'd4, 32'd5);
        pop(4'd0);

        // R9 drop while valid, R8 non-status read keeps valid
        tx_start = 1; tick();
        ld(32'h600, 32'h3000);
        viol(32'h600, 3'd2);
        viol(32'h700, 3'd3);
        tx_abort = 1; tick();
        check("R9", 4'd1, 32'h600);
        check("R9", 4'd2, 32'h3000);
        check("R9", 4'd3, 32'd2);
        check("R5", 4'd4, 32'd1);
        check("R9", 4'd0, stat(1, 7, 1));
        pop(4'd1);
        check("R8", 4'd0, stat(1, 7, 1));

        // R10: burst of violations saturates both counts
        repeat (300) begin viol_valid = 1; viol_addr = 32'h900; tick(); end
        check("R10", 4'd0, stat(1, 255, 255));
        check("R10", 4'd1, 32'h600);
        pop(4'd0);

        // R6: overflow record completes at commit
        tx_start = 1; tick();
        ovf_valid = 1; ovf_type = 2'd2; ovf_pc = 32'h2000; tick();
        repeat (5) tick();
        check("R6", 4'd5, stat(0, 1, 0));
        tx_commit = 1; tick();
        check("R6", 4'd5, stat(1, 1, 0));
        check("R6", 4'd6, 32'h2000);
        check("R6", 4'd7, 32'd2);
        check("R6", 4'd8, 32'd5);

        // R9 on overflow: drop while valid
        tx_start = 1; tick();
        ovf_valid = 1; ovf_type = 2'd1; ovf_pc = 32'h2222; tick();
        tx_commit = 1; tick();
        check("R9", 4'd6, 32'h2000);
        check("R9", 4'd5, stat(1, 2, 1));
        pop(4'd5);
        check("R8", 4'd5, stat(0, 2, 1));

        // R7: abort discards a pending overflow
        tx_start = 1; tick();
        ovf_valid = 1; ovf_type = 2'd3; ovf_pc = 32'h4444; tick();
        repeat (2) tick();
        tx_abort = 1; tick();
        check("R7", 4'd5, stat(0, 3, 1));
        tx_start = 1; tick();
        tx_commit = 1; tick();
        check("R7", 4'd5, stat(0, 3, 1));
        check("R7", 4'd8, 32'd5);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule